// File: doc/BRIEF.md
# Packed Lane Integer ALU

This block applies one integer operation to every lane of two 64-bit operands at once. A size input splits the operands into eight 8-bit, four 16-bit or two 32-bit lanes. The arithmetic operations are add and subtract, each in one of three forms: plain modular, clamped to the signed range, or clamped to the unsigned range. Two compare operations, equality and signed greater-than, return a lane filled with all ones when the test holds and all zeros when it does not. The result can then serve directly as a select mask for the bitwise AND, AND-NOT, OR and XOR operations, which always act on the whole 64-bit word.

No condition flags are produced. Every outcome lands in the 64-bit result word. A request is qualified by `in_valid`. Exactly one clock later the block raises `out_valid` with the registered result. A common use is per-byte absolute difference: issue two unsigned clamped subtracts with the operands swapped, then OR the two results.

Top module: `simd_packed_alu`

## Requirements
- R1: `size` selects the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes, and both 2 and 3 give 32-bit lanes. No carry or borrow passes from one lane into the next.
- R2: Opcode 0 (add) and opcode 3 (subtract, a minus b) return each lane's result modulo 2^width.
- R3: Opcode 1 (add) and opcode 4 (subtract) treat lanes as two's complement. A result above the signed maximum becomes that maximum (for bytes, 0x7F). A result below the signed minimum becomes that minimum (for bytes, 0x80).
- R4: Opcode 2 (add) and opcode 5 (subtract) treat lanes as unsigned. A sum above the lane maximum becomes all ones, and a difference below zero becomes zero. Because of this, OR-ing the results of a minus b and b minus a gives the per-lane absolute difference.
- R5: Opcode 6 sets a lane to all ones when the two lanes are equal. Opcode 7 does the same when lane a is greater than lane b as signed values. In every other case the lane is all zeros.
- R6: Opcodes 8 (a AND b), 9 ((NOT a) AND b), 10 (OR) and 11 (XOR) act on all 64 bits, whatever `size` is.
- R7: `out_valid` is high in the cycle after a cycle in which `in_valid` was high, and `y` then holds the result for that request.
- R8: While `rst_n` is low at a rising clock edge, `out_valid` and `y` are both cleared to zero. The reset is synchronous.
- R9: When `in_valid` is low, `y` keeps its previous value, whatever the other inputs do.
- R10: Opcodes 12 to 15 yield a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request qualifier |
| op | input | 4 | Operation code (see R2 to R6 and R10) |
| size | input | 2 | Lane width select (see R1) |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| out_valid | output | 1 | Result qualifier, one cycle after the request |
| y | output | 64 | Registered packed result |

## Verification
The embedded properties check the following on every cycle:
- the one-cycle valid latency and the reset clearing;
- that `y` holds when no request was taken;
- that every byte of a compare result is either 0x00 or 0xFF;
- that byte-wide unsigned clamped add never falls below its first operand, and unsigned clamped subtract never rises above it.

The exact lane values are shown only by the scoreboard scenarios, which compare each result against an independent integer model:
- wrap-around versus clamping at each width;
- that no carry crosses a lane boundary;
- equal and signed greater-than at all widths;
- the absolute-difference idiom;
- the reserved opcodes.

// File: rtl/simd_alu_pkg.sv
// Package: shared operation codes for the packed lane ALU.
// Assumes a 4-bit operation field. Values 12..15 are reserved and produce zero.
package simd_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_ADDS   = 4'd1,
        OP_ADDUS  = 4'd2,
        OP_SUB    = 4'd3,
        OP_SUBS   = 4'd4,
        OP_SUBUS  = 4'd5,
        OP_CMPEQ  = 4'd6,
        OP_CMPGT  = 4'd7,
        OP_AND    = 4'd8,
        OP_ANDN   = 4'd9,
        OP_OR     = 4'd10,
        OP_XOR    = 4'd11,
        OP_RSV12  = 4'd12,
        OP_RSV13  = 4'd13,
        OP_RSV14  = 4'd14,
        OP_RSV15  = 4'd15
    } alu_op_e;

endpackage

// File: rtl/simd_lane_arith.sv
// Module: one lane of add/subtract/compare.
// It works on one lane of LANE_W bits, with no carry in from and no carry out to its neighbours.
// Clamping decisions use only this lane's sign bits and carry.
// Non-arithmetic opcodes give zero here; the top module selects another source for them.
module simd_lane_arith
    import simd_alu_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  alu_op_e             op,
    input  logic [LANE_W-1:0]   a,
    input  logic [LANE_W-1:0]   b,
    output logic [LANE_W-1:0]   res
);

    localparam logic [LANE_W-1:0] ALL_ONES = {LANE_W{1'b1}};
    localparam logic [LANE_W-1:0] SIGN_MAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] SIGN_MIN = {1'b1, {(LANE_W-1){1'b0}}};

    logic               is_sub;
    logic [LANE_W-1:0]  b_eff;
    logic [LANE_W:0]    wide;
    logic [LANE_W-1:0]  raw;
    logic               carry;
    logic               sgn_ovf;
    logic               uns_ovf;
    logic               eq_hit;
    logic               gt_hit;

    // Purpose: decide whether this opcode subtracts.
    always_comb begin
        is_sub = (op == OP_SUB) || (op == OP_SUBS) || (op == OP_SUBUS);
    end

    // Purpose: one shared adder; a subtract adds the inverted b plus one.
    always_comb begin
        b_eff = is_sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{LANE_W{1'b0}}, is_sub};
        raw   = wide[LANE_W-1:0];
        carry = wide[LANE_W];
    end

    // Purpose: find signed and unsigned overflow from this lane's own bits.
    always_comb begin
        sgn_ovf = (a[LANE_W-1] == b_eff[LANE_W-1]) && (raw[LANE_W-1] != a[LANE_W-1]);
        uns_ovf = is_sub ? ~carry : carry;
    end

    // Purpose: compute the two compare predicates.
    always_comb begin
        eq_hit = (a == b);
        gt_hit = ($signed(a) > $signed(b));
    end

    // Purpose: choose the lane result for the requested operation.
    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB:     res = raw;
            OP_ADDS, OP_SUBS:   res = sgn_ovf ? (a[LANE_W-1] ? SIGN_MIN : SIGN_MAX) : raw;
            OP_ADDUS:           res = uns_ovf ? ALL_ONES : raw;
            OP_SUBUS:           res = uns_ovf ? '0 : raw;
            OP_CMPEQ:           res = {LANE_W{eq_hit}};
            OP_CMPGT:           res = {LANE_W{gt_hit}};
            default:            res = '0;
        endcase
    end

endmodule

// File: rtl/simd_width_slice.sv
// Module: the full data word cut into lanes of one fixed width.
// Assumes DATA_W is a whole multiple of LANE_W. Each lane is an independent instance.
module simd_width_slice
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [DATA_W-1:0]   res
);

    localparam int LANES = DATA_W / LANE_W;

    // Purpose: one arithmetic lane per slot, with no chaining between them.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        simd_lane_arith #(
            .LANE_W (LANE_W)
        ) u_lane (
            .op  (op),
            .a   (a[l*LANE_W +: LANE_W]),
            .b   (b[l*LANE_W +: LANE_W]),
            .res (res[l*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/simd_bitwise.sv
// Module: whole-word logic operations that ignore the lane size.
// Opcodes other than the four logic codes give zero.
module simd_bitwise
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [DATA_W-1:0]   res
);

    // Purpose: apply the selected bitwise function to the full word.
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_ANDN: res = ~a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/simd_packed_alu.sv
// Module: top of the packed lane ALU.
// It evaluates all lane widths side by side, picks one by size,
// and registers the result together with a valid bit.
// Assumes a synchronous active-low reset, and that y holds between requests.
module simd_packed_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W      = 64,
    parameter int BASE_LANE_W = 8,
    parameter int NUM_SIZES   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [3:0]          op,
    input  logic [1:0]          size,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic                out_valid,
    output logic [DATA_W-1:0]   y
);

    localparam int NUM_BYTES = DATA_W / 8;
    localparam logic [1:0] TOP_SIZE = 2'(NUM_SIZES - 1);

    alu_op_e            op_e;
    logic [1:0]         size_idx;
    logic [DATA_W-1:0]  arith_res [NUM_SIZES];
    logic [DATA_W-1:0]  sel_arith;
    logic [DATA_W-1:0]  logic_res;
    logic [DATA_W-1:0]  next_y;

    // Purpose: read the opcode as the package enum and fold size values above the widest width.
    always_comb begin
        op_e     = alu_op_e'(op);
        size_idx = (size > TOP_SIZE) ? TOP_SIZE : size;
    end

    // Purpose: one lane slice per supported width, each width double the one before.
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_width
        simd_width_slice #(
            .DATA_W (DATA_W),
            .LANE_W (BASE_LANE_W << g)
        ) u_slice (
            .op  (op_e),
            .a   (a),
            .b   (b),
            .res (arith_res[g])
        );
    end

    simd_bitwise #(
        .DATA_W (DATA_W)
    ) u_bitwise (
        .op  (op_e),
        .a   (a),
        .b   (b),
        .res (logic_res)
    );

    // Purpose: choose the slice output that matches the requested width.
    always_comb begin
        sel_arith = '0;
        for (int g = 0; g < NUM_SIZES; g++) begin
            if (size_idx == 2'(g)) sel_arith = arith_res[g];
        end
    end

    // Purpose: the top opcode bit separates bitwise/reserved codes from arithmetic codes.
    always_comb begin
        next_y = op[3] ? logic_res : sel_arith;
    end

    // Purpose: output register; it loads only on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            y         <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) y <= next_y;
        end
    end

    // R7: valid appears exactly one cycle after the request.
    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R8: the first cycle after reset shows cleared outputs.
    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!out_valid && (y == '0)));

    // R9: no accepted request means the result holds.
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(y));

    // Byte-level properties on the registered result.
    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_chk
        // R5: every byte of a compare result is 0x00 or 0xFF at any lane width.
        assert_cmp_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && ($past(op) == 4'(OP_CMPEQ) || $past(op) == 4'(OP_CMPGT)))
            |-> (y[k*8 +: 8] == 8'h00 || y[k*8 +: 8] == 8'hFF));

        // R4: an unsigned clamped byte add never drops below its first operand.
        assert_usat_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(op) == 4'(OP_ADDUS) && $past(size) == 2'd0)
            |-> (y[k*8 +: 8] >= $past(a[k*8 +: 8])));

        // R4: an unsigned clamped byte subtract never rises above its first operand.
        assert_usat_sub_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(op) == 4'(OP_SUBUS) && $past(size) == 2'd0)
            |-> (y[k*8 +: 8] <= $past(a[k*8 +: 8])));
    end

endmodule

// File: tb/tb_simd_packed_alu.sv
// Scoreboard bench: the driver queues the value each request should produce, and the monitor checks each result against it.
module tb_simd_packed_alu;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  size = '0;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic        out_valid;
    logic [63:0] y;

    int          n_checks = 0;
    int          n_fails  = 0;
    bit          done     = 1'b0;
    exp_item_t   exp_q[$];
    logic [63:0] last_y = '0;
    logic [63:0] prev_y = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_packed_alu dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .size      (size),
        .a         (a),
        .b         (b),
        .out_valid (out_valid),
        .y         (y)
    );

    function automatic longint clampv(input longint v, input longint lo, input longint hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // Independent integer model of the requirements.
    function automatic logic [63:0] model(input logic [3:0] o, input logic [1:0] s,
                                          input logic [63:0] x, input logic [63:0] z);
        int w;
        longint umax, smax, smin, ua, ub, sa, sb, r;
        logic [63:0] out;
        out = '0;
        case (o)
            4'd8:  return x & z;
            4'd9:  return ~x & z;
            4'd10: return x | z;
            4'd11: return x ^ z;
            default: ;
        endcase
        if (o > 4'd11) return '0;
        w    = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
        umax = (longint'(1) << w) - 1;
        smax = (longint'(1) << (w - 1)) - 1;
        smin = -smax - 1;
        for (int l = 0; l < 64 / w; l++) begin
            ua = longint'(x >> (l * w)) & umax;
            ub = longint'(z >> (l * w)) & umax;
            sa = (ua > smax) ? ua - umax - 1 : ua;
            sb = (ub > smax) ? ub - umax - 1 : ub;
            case (o)
                4'd0:    r = ua + ub;
                4'd1:    r = clampv(sa + sb, smin, smax);
                4'd2:    r = clampv(ua + ub, 0, umax);
                4'd3:    r = ua - ub;
                4'd4:    r = clampv(sa - sb, smin, smax);
                4'd5:    r = clampv(ua - ub, 0, umax);
                4'd6:    r = (ua == ub) ? umax : 0;
                default: r = (sa > sb) ? umax : 0;
            endcase
            out = out | (64'(r & umax) << (l * w));
        end
        return out;
    endfunction

    function automatic string tag_of(input logic [3:0] o, input logic [1:0] s);
        string t;
        if (o == 4'd0 || o == 4'd3)      t = "R2";
        else if (o == 4'd1 || o == 4'd4) t = "R3";
        else if (o == 4'd2 || o == 4'd5) t = "R4";
        else if (o == 4'd6 || o == 4'd7) t = "R5";
        else if (o < 4'd12)              t = "R6";
        else                             t = "R10";
        if (o < 4'd8) t = {t, "/R1"};
        return $sformatf("%s op=%0d size=%0d", t, o, s);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: present one request and queue its expected result (R7).
    task automatic send(input logic [3:0] o, input logic [1:0] s,
                        input logic [63:0] x, input logic [63:0] z);
        exp_item_t it;
        @(negedge clk);
        op = o; size = s; a = x; b = z; in_valid = 1'b1;
        it.exp = model(o, s, x, z);
        it.tag = tag_of(o, s);
        exp_q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pop and compare whenever a result is presented.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            prev_y = last_y;
            last_y = y;
            if (exp_q.size() == 0) begin
                check("R7 unexpected out_valid", 64'd1, 64'd0);
            end else begin
                exp_item_t it;
                it = exp_q.pop_front();
                check(it.tag, y, it.exp);
            end
        end
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R8: the reset state.
        check("R8 out_valid in reset", {63'd0, out_valid}, 64'd0);
        check("R8 y in reset", y, 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1: no carry crosses a lane boundary, at each width.
        send(4'd0, 2'd0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001);
        send(4'd0, 2'd1, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001);
        send(4'd0, 2'd2, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001);
        send(4'd0, 2'd3, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001);
        send(4'd3, 2'd0, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101);
        // R3: signed clamping at the positive and negative ends.
        send(4'd1, 2'd0, 64'h7F7F_7F7F_8080_8080, 64'h0101_0101_FFFF_FFFF);
        send(4'd4, 2'd1, 64'h8000_7FFF_0005_FFFE, 64'h0001_FFFF_0003_0001);
        send(4'd1, 2'd2, 64'h7FFF_FFF0_8000_0001, 64'h0000_0100_FFFF_FFFE);
        // R4: unsigned clamping.
        send(4'd2, 2'd0, 64'hFF80_0102_F0F0_0000, 64'h0180_FEFE_2020_0000);
        send(4'd5, 2'd1, 64'h0001_FFFF_1000_0000, 64'h0002_0001_0FFF_0001);
        send(4'd5, 2'd2, 64'h0000_0010_FFFF_FFFF, 64'h0000_0020_0000_0001);
        // R5: compare masks, including signed ordering of negative values.
        send(4'd6, 2'd0, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700);
        send(4'd7, 2'd0, 64'h7F80_0001_FF00_0505, 64'h807F_FF00_00FF_0505);
        send(4'd7, 2'd1, 64'h8000_0001_7FFF_1234, 64'h7FFF_FFFF_8000_1234);
        send(4'd7, 2'd2, 64'h0000_0001_8000_0000, 64'hFFFF_FFFF_7FFF_FFFF);
        // R6: bitwise operations ignore the size field.
        send(4'd8, 2'd1, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_FFFF);
        send(4'd9, 2'd0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_FFFF);
        send(4'd10, 2'd2, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_FFFF);
        send(4'd11, 2'd3, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_FFFF);
        // R10: reserved opcodes.
        send(4'd12, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0);
        send(4'd15, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0);
        idle(2);

        // R4: absolute difference from two unsigned clamped subtracts.
        send(4'd5, 2'd0, 64'h0A1E_FF00_6464_0180, 64'h1E0A_00FF_6400_8001);
        send(4'd5, 2'd0, 64'h1E0A_00FF_6400_8001, 64'h0A1E_FF00_6464_0180);
        idle(2);
        check("R4 absolute difference", prev_y | last_y, 64'h1414_FFFF_0064_7F7F);

        // R9: y holds while no request is taken, whatever the other inputs are.
        held = last_y;
        @(negedge clk);
        op = 4'd11; size = 2'd1; a = 64'hDEAD_BEEF_0000_FFFF; b = 64'h1; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 y held", y, held);
        check("R7 no out_valid while idle", {63'd0, out_valid}, 64'd0);

        // Mixed traffic, sent back to back, with edge values favoured.
        for (int i = 0; i < 600; i++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (i % 4 == 1) ra = ra | 64'h8080_8080_8080_8080;
            if (i % 4 == 2) rb = rb & 64'h7F7F_7F7F_7F7F_7F7F;
            if (i % 7 == 3) rb = ra;
            send(4'($urandom_range(15)), 2'($urandom_range(3)), ra, rb);
            if (i % 9 == 0) idle(1);
        end
        idle(3);
        check("R7 scoreboard drained", 64'(exp_q.size()), 64'd0);

        // R8: reset after activity clears the outputs.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R8 y after reset", y, 64'd0);
        check("R8 out_valid after reset", {63'd0, out_valid}, 64'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule